// File: doc/BRIEF.md
# Grouped Tick-Rate Generator

This block turns one base clock into five independent tick-enable streams for a bank of timer channels. Two 8-bit prescalers run in parallel. The first feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then applies its own power-of-two divider to the prescaled tick. A channel can instead follow an external tick input, which is synchronised and reduced to rising edges inside the block. Every output is a single-cycle pulse in the base clock domain. A downstream counter uses it as its count enable.

Each prescaler is a two-state machine. `PS_RESTART` loads the new ratio and clears the counter. `PS_RUN` counts from 0 up to the ratio. A change to the ratio moves `PS_RUN` to `PS_RESTART`, and `PS_RESTART` always returns to `PS_RUN` on the next edge. Each channel's source machine has three states:

- `DV_RESTART` latches the selector and clears the divider.
- `DV_DIV` counts prescaled ticks.
- `DV_EXT` passes synchronised external edges.

A selector change moves `DV_DIV` or `DV_EXT` to `DV_RESTART`. `DV_RESTART` goes to `DV_EXT` when the new code is an external code, and otherwise to `DV_DIV`. While its group's prescaler is restarting, the divider counter is held at zero, so the divider and the prescaler start again in phase.

Top module: `tick_source_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `tick_en` is 0.
- R2: Prescaler A is `cfg_prescale[7:0]` and serves channels 0 and 1. Prescaler B is `cfg_prescale[15:8]` and serves channels 2, 3 and 4. Changing one prescaler does not alter the pulse spacing of the other group.
- R3: A prescaler of value P yields one prescaled tick every P+1 base clock cycles.
- R4: Channel n reads its selector from `cfg_select[4n+3:4n]`. A non-external code s gives a steady pulse period of (P+1)·2^min(s+DIV_BASE, MAX_EXP) cycles. The defaults are DIV_BASE=0 and MAX_EXP=4, so codes 4 and above, other than code 5, all divide by 16.
- R5: The selector codes flagged in EXT_MASK route an external input to the channel; by default this is code 5 only. Channels 0 and 1 follow `ext_tick_in[0]`, and channels 2 to 4 follow `ext_tick_in[1]`. Each rising edge of that input, with the input held at least 2 cycles high and 2 cycles low, gives exactly one output pulse.
- R6: When the period is greater than one cycle, an output pulse is never high on two consecutive cycles.
- R7: A prescaler change restarts its group. The first pulse of a channel in that group appears exactly (new period)+2 cycles after the change, when the change is applied in the cycle the channel shows a pulse.
- R8: After a selector change, the channel gives no pulse in the next 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 16 | Two prescaler ratios, group A in the low byte |
| cfg_select | input | 20 | Five 4-bit source selectors, channel n at bits 4n+3:4n |
| ext_tick_in | input | 2 | Asynchronous external tick sources, one per group |
| tick_en | output | 5 | Single-cycle tick enables, one per channel |

## Verification
Two events can fall in the same cycle: a configuration change and a terminal count in the divider. The bench provokes this by waiting for the cycle in which a channel shows a pulse and changing the prescaler ratio or the selector right then. For a prescaler change, it checks that the next pulse lands exactly at the new period plus the two-cycle restart. For a selector change, it checks that no stray pulse appears during the restart cycles. Steady-state spacing is then measured over a sweep of ratios and codes, with each expected period computed arithmetically.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

    typedef enum logic [0:0] {
        PS_RESTART = 1'b0,
        PS_RUN     = 1'b1
    } ps_state_e;

    typedef enum logic [1:0] {
        DV_RESTART = 2'd0,
        DV_DIV     = 2'd1,
        DV_EXT     = 2'd2
    } dv_state_e;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_sel_pkg::*;
#(
    parameter int unsigned PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ratio_i,
    output logic            tick_o,
    output logic            hold_o
);

    ps_state_e       state_q, state_d;
    logic [PS_W-1:0] ratio_q;
    logic [PS_W-1:0] cnt_q;
    logic            cfg_moved;

    assign cfg_moved = (ratio_i != ratio_q);

    // state register and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RESTART;
            ratio_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                PS_RESTART: begin
                    ratio_q <= ratio_i;
                    cnt_q   <= '0;
                end
                PS_RUN: begin
                    if (cfg_moved || (cnt_q == ratio_q)) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + PS_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RESTART: state_d = PS_RUN;
            PS_RUN:     state_d = cfg_moved ? PS_RESTART : PS_RUN;
            default:    state_d = PS_RESTART;
        endcase
    end

    // outputs
    always_comb begin
        tick_o = 1'b0;
        hold_o = 1'b1;
        unique case (state_q)
            PS_RESTART: begin
                tick_o = 1'b0;
                hold_o = 1'b1;
            end
            PS_RUN: begin
                tick_o = !cfg_moved && (cnt_q == ratio_q);
                hold_o = cfg_moved;
            end
            default: begin
                tick_o = 1'b0;
                hold_o = 1'b1;
            end
        endcase
    end

    AST_PS_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && !cfg_moved) |-> (cnt_q <= ratio_q)); // R3

    AST_PS_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && cfg_moved) |=> (state_q == PS_RESTART && cnt_q == '0)); // R7

endmodule

// File: rtl/tick_ext_sync.sv
module tick_ext_sync #(
    parameter int unsigned N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_i,
    output logic [N_EXT-1:0] edge_o
);

    logic [N_EXT-1:0] meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= ext_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_edge
        assign edge_o[i] = sync_q[i] & ~last_q[i];

        AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            edge_o[i] |=> !edge_o[i]); // R5
    end

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import tick_sel_pkg::*;
#(
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned MAX_EXP  = 4,
    parameter int unsigned DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ps_tick_i,
    input  logic             hold_i,
    input  logic             ext_edge_i,
    output logic             tick_o
);

    localparam int unsigned CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    function automatic logic [CNT_W-1:0] lim_for(input logic [SEL_W-1:0] s);
        int e;
        e = int'(s) + int'(DIV_BASE);
        if (e > int'(MAX_EXP)) e = int'(MAX_EXP);
        return CNT_W'((1 << e) - 1);
    endfunction

    dv_state_e        state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] dcnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             sel_moved;
    logic             tick_d, tick_q;

    assign sel_moved = (sel_i != sel_q);
    assign lim_q     = lim_for(sel_q);

    // state register and divider counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DV_RESTART;
            sel_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                DV_RESTART: begin
                    sel_q  <= sel_i;
                    dcnt_q <= '0;
                end
                DV_DIV: begin
                    if (sel_moved || hold_i) begin
                        dcnt_q <= '0;
                    end else if (ps_tick_i) begin
                        dcnt_q <= (dcnt_q == lim_q) ? '0 : dcnt_q + CNT_W'(1);
                    end
                end
                DV_EXT:  dcnt_q <= '0;
                default: dcnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_RESTART: state_d = EXT_MASK[sel_i] ? DV_EXT : DV_DIV;
            DV_DIV:     state_d = sel_moved ? DV_RESTART : DV_DIV;
            DV_EXT:     state_d = sel_moved ? DV_RESTART : DV_EXT;
            default:    state_d = DV_RESTART;
        endcase
    end

    // output decode
    always_comb begin
        tick_d = 1'b0;
        unique case (state_q)
            DV_RESTART: tick_d = 1'b0;
            DV_DIV:     tick_d = !sel_moved && !hold_i && ps_tick_i && (dcnt_q == lim_q);
            DV_EXT:     tick_d = !sel_moved && ext_edge_i;
            default:    tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;

    AST_DIV_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_DIV) |-> (dcnt_q <= lim_q)); // R4

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_RESTART) |=> !tick_o); // R8

    AST_EXT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_EXT && !ext_edge_i) |=> !tick_o); // R5

    AST_DIV_NEEDS_PS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_DIV && !ps_tick_i) |=> !tick_o); // R3

endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel #(
    parameter int unsigned N_CH     = 5,
    parameter int unsigned GRP0_CH  = 2,
    parameter int unsigned PS_W     = 8,
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned MAX_EXP  = 4,
    parameter int unsigned DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0020
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*PS_W-1:0]     cfg_prescale,
    input  logic [N_CH*SEL_W-1:0] cfg_select,
    input  logic [1:0]            ext_tick_in,
    output logic [N_CH-1:0]       tick_en
);

    localparam int unsigned N_GRP = 2;

    logic [N_GRP-1:0] ps_tick;
    logic [N_GRP-1:0] ps_hold;
    logic [N_GRP-1:0] ext_edge;

    for (genvar g = 0; g < N_GRP; g++) begin : g_ps
        tick_prescaler #(
            .PS_W (PS_W)
        ) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .ratio_i (cfg_prescale[g*PS_W +: PS_W]),
            .tick_o  (ps_tick[g]),
            .hold_o  (ps_hold[g])
        );
    end

    tick_ext_sync #(
        .N_EXT (N_GRP)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_tick_in),
        .edge_o (ext_edge)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int GRP = (c < int'(GRP0_CH)) ? 0 : 1;

        tick_divider #(
            .SEL_W    (SEL_W),
            .MAX_EXP  (MAX_EXP),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (cfg_select[c*SEL_W +: SEL_W]),
            .ps_tick_i  (ps_tick[GRP]),
            .hold_i     (ps_hold[GRP]),
            .ext_edge_i (ext_edge[GRP]),
            .tick_o     (tick_en[c])
        );
    end

    AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tick_en == '0)); // R1

endmodule

// File: tb/sim_tick_source_sel.sv
module sim_tick_source_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_prescale = '0;
    logic [19:0] cfg_select = '0;
    logic [1:0]  ext_tick_in = '0;
    logic [4:0]  tick_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_source_sel u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_prescale (cfg_prescale),
        .cfg_select   (cfg_select),
        .ext_tick_in  (ext_tick_in),
        .tick_en      (tick_en)
    );

    // pulse statistics gathered away from the active edge
    bit         clr = 0;
    int         since[NCH];
    int         gmin[NCH];
    int         gmax[NCH];
    int         npulse[NCH];
    int         ndbl[NCH];
    bit         seen[NCH];
    logic [4:0] prev = '0;

    always @(negedge clk) begin
        for (int ch = 0; ch < NCH; ch++) begin
            if (clr) begin
                since[ch] = 0; gmin[ch] = 1 << 30; gmax[ch] = 0;
                npulse[ch] = 0; ndbl[ch] = 0; seen[ch] = 0;
            end else if (tick_en[ch]) begin
                if (prev[ch]) ndbl[ch]++;
                if (seen[ch]) begin
                    if (since[ch] < gmin[ch]) gmin[ch] = since[ch];
                    if (since[ch] > gmax[ch]) gmax[ch] = since[ch];
                end
                seen[ch] = 1;
                since[ch] = 1;
                npulse[ch]++;
            end else begin
                since[ch]++;
            end
        end
        prev = tick_en;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_stats();
        clr = 1;
        step(1);
        clr = 0;
    endtask

    function automatic int period_of(input int p, input int code);
        int e;
        e = (code > 4) ? 4 : code;
        return (p + 1) << e;
    endfunction

    task automatic ext_pulses(input int idx, input int n);
        repeat (n) begin
            ext_tick_in[idx] = 1'b1;
            step(4);
            ext_tick_in[idx] = 1'b0;
            step(4);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int codes[6];
        int pvals[3];
        int bad;
        int gap;
        codes[0] = 0; codes[1] = 1; codes[2] = 2;
        codes[3] = 3; codes[4] = 4; codes[5] = 9;
        pvals[0] = 0; pvals[1] = 1; pvals[2] = 3;

        // R1: silent during reset and on the first cycle after
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            if (tick_en != '0) bad++;
        end
        check(bad == 0, "R1 tick_en in reset", bad, 0);
        rst_n = 1'b1;
        step(1);
        check(tick_en == '0, "R1 first cycle after reset", int'(tick_en), 0);

        // R2 R3 R4 R6: sweep of ratios and selector codes
        for (int pi = 0; pi < 3; pi++) begin
            for (int k = 0; k < 6; k++) begin
                int p0;
                int p1;
                int maxper;
                p0 = pvals[pi];
                p1 = pvals[pi] + 2;
                cfg_prescale = {8'(p1), 8'(p0)};
                for (int ch = 0; ch < NCH; ch++)
                    cfg_select[ch*4 +: 4] = 4'(codes[(k + ch) % 6]);
                maxper = period_of(p1, 4);
                step(6);
                clear_stats();
                step(3 * maxper + 10);
                for (int ch = 0; ch < NCH; ch++) begin
                    int exp;
                    int code;
                    code = codes[(k + ch) % 6];
                    exp = period_of((ch < 2) ? p0 : p1, code);
                    check(npulse[ch] >= 2 && gmin[ch] == exp && gmax[ch] == exp,
                          (ch < 2) ? "R2 R3 R4 period group A" : "R2 R3 R4 period group B",
                          gmax[ch], exp);
                    if (exp > 1)
                        check(ndbl[ch] == 0, "R6 single-cycle pulse", ndbl[ch], 0);
                end
            end
        end

        // R5: external sources per group
        cfg_prescale = 16'h0000;
        cfg_select = {5{4'd5}};
        step(6);
        clear_stats();
        ext_pulses(0, 6);
        ext_pulses(1, 3);
        step(6);
        for (int ch = 0; ch < NCH; ch++)
            check(npulse[ch] == ((ch < 2) ? 6 : 3), "R5 external edge count",
                  npulse[ch], (ch < 2) ? 6 : 3);
        check(ndbl[0] == 0 && ndbl[2] == 0, "R5 external pulse width", ndbl[0] + ndbl[2], 0);

        // R7: prescaler change coinciding with a pulse
        cfg_prescale = 16'h0302;
        cfg_select = {4'd1, 4'd1, 4'd1, 4'd1, 4'd1};
        step(40);
        do step(1); while (!tick_en[0]);
        cfg_prescale[7:0] = 8'd4;
        gap = 0;
        do begin
            step(1);
            gap++;
        end while (!tick_en[0] && gap < 200);
        check(gap == period_of(4, 1) + 2, "R7 restart latency ch0", gap, period_of(4, 1) + 2);
        // group B kept its spacing
        clear_stats();
        step(60);
        check(gmin[3] == period_of(3, 1) && gmax[3] == period_of(3, 1),
              "R2 other group unaffected", gmax[3], period_of(3, 1));

        // R8: selector change coinciding with a pulse
        for (int t = 0; t < 2; t++) begin
            do step(1); while (!tick_en[4]);
            cfg_select[19:16] = (t == 0) ? 4'd0 : 4'd1;
            bad = 0;
            for (int i = 0; i < 2; i++) begin
                step(1);
                if (tick_en[4]) bad++;
            end
            check(bad == 0, "R8 quiet after selector change", bad, 0);
        end

        finish_run();
    end

endmodule